// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit segment and a 16-bit offset into a physical byte address the way a legacy real-mode processor does: the segment is scaled by sixteen and the offset is added. The sum can need 21 bits. Two inputs shape how that top bit is treated. A bus-width select chooses a 20-bit legacy bus, where the sum wraps modulo 2^20, or a 24-bit bus, where the carry into bit 20 is kept. A compatibility gate can force bit 20 low so that software written for the wrapping machine still sees the wrap on the wider bus.

The block also owns a stack-segment register and a stack pointer. It forms addresses for word pushes and pops on a stack that grows downward and stays inside one 64 KB segment. A load request writes both stack registers from the segment and offset inputs. Every address request returns a registered 24-bit address with a one-cycle valid strobe. Requests may be issued on back-to-back cycles.

Top module: `rm_addr_gen`

## Requirements
- R1: For an access request (req_op = 0) with wide_bus = 1 and hi_bit_en = 1, phys_addr equals 16*seg + off with all 21 bits kept. The largest value is 0x10FFEF, from seg 0xFFFF and off 0xFFFF.
- R2: With wide_bus = 0, phys_addr equals (16*seg + off) modulo 2^20. For example, FFFF:0010 gives 0x00000.
- R3: With hi_bit_en = 0, phys_addr bit 20 is 0 in either bus mode. Bits 19..0 are unchanged, so FFFF:FFFF gives 0x0FFEF.
- R4: phys_addr bits 23..21 are always 0.
- R5: A request with req_op = 0, 1 or 2 raises addr_valid for exactly one cycle, in the cycle after the request clock edge. A load request (req_op = 3) or an idle cycle leaves addr_valid low.
- R6: A push (req_op = 1) lowers the stack pointer by 2 and issues stack_seg*16 + the new pointer.
- R7: A pop (req_op = 2) issues stack_seg*16 + the current pointer and then raises the pointer by 2.
- R8: Stack pointer arithmetic wraps within 16 bits. A push at 0x0000 gives 0xFFFE, and a pop at 0xFFFE gives 0x0000.
- R9: A load (req_op = 3) sets the stack segment to seg and the stack pointer to off. An access request leaves both stack registers unchanged.
- R10: While rst_n is low, addr_valid is 0, phys_addr is 0, and the stack segment and stack pointer are 0x0000.
- R11: Stack addresses pass through the same bus-width and gate rules as R1 to R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 access, 1 push, 2 pop, 3 load stack registers |
| seg | input | 16 | Segment value (stack segment for a load) |
| off | input | 16 | Offset value (stack pointer for a load) |
| wide_bus | input | 1 | 1 = 24-bit bus keeps carry, 0 = 20-bit wrap |
| hi_bit_en | input | 1 | 1 = address bit 20 passes, 0 = forced low |
| phys_addr | output | 24 | Registered physical byte address |
| addr_valid | output | 1 | One-cycle strobe marking phys_addr |

## Verification
The bench targets the 0xFFFF segment with offsets on both sides of 0x000F, under all four combinations of bus width and gate. A design that drops the carry would return 0x0FFEF instead of 0x10FFEF. A design that ignores the gate would leak bit 20 into a wrapped address. It also drives the stack pointer across zero in both directions. A design that widens or saturates the pointer arithmetic would produce addresses outside the segment or stop at 0x0000. The bench checks pre-decrement on push against post-increment on pop. Swapping them shifts every stack address by two. It also confirms that a load raises no strobe and that an access request leaves the stack pointer unchanged.

// File: rtl/rmag_pkg.sv
package rmag_pkg;
  localparam int unsigned SEG_W    = 16;
  localparam int unsigned OFF_W    = 16;
  localparam int unsigned SHIFT    = 4;
  localparam int unsigned PA_W     = 24;
  localparam int unsigned LEGACY_W = 20;

  typedef enum logic [1:0] {
    OP_ACCESS = 2'd0,
    OP_PUSH   = 2'd1,
    OP_POP    = 2'd2,
    OP_LOAD   = 2'd3
  } rmag_op_e;
endpackage

// File: rtl/rmag_xlate.sv
module rmag_xlate #(
  parameter int unsigned SEG_W    = 16,
  parameter int unsigned OFF_W    = 16,
  parameter int unsigned SHIFT    = 4,
  parameter int unsigned PA_W     = 24,
  parameter int unsigned LEGACY_W = 20
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             wide_i,
  input  logic             gate_i,
  output logic [PA_W-1:0]  pa_o
);
  localparam int unsigned SCALED_W = SEG_W + SHIFT;
  localparam int unsigned SUM_W    = ((SCALED_W > OFF_W) ? SCALED_W : OFF_W) + 1;

  logic [SUM_W-1:0] scaled;
  logic [SUM_W-1:0] sum;

  assign scaled = SUM_W'({seg_i, {SHIFT{1'b0}}});
  assign sum    = scaled + SUM_W'(off_i);

  always_comb begin
    pa_o = '0;
    pa_o[LEGACY_W-1:0] = sum[LEGACY_W-1:0];
    if (wide_i) begin
      pa_o[SUM_W-1:LEGACY_W] = sum[SUM_W-1:LEGACY_W];
    end
    if (!gate_i) begin
      pa_o[LEGACY_W] = 1'b0;
    end
  end

  always_comb begin
    assert_low_bits_R2: assert (pa_o[LEGACY_W-1:0] == sum[LEGACY_W-1:0])
      else $error("low address bits altered by translation");
  end
endmodule

// File: rtl/rmag_stack.sv
module rmag_stack
  import rmag_pkg::*;
#(
  parameter int unsigned SEG_W      = 16,
  parameter int unsigned OFF_W      = 16,
  parameter int unsigned WORD_BYTES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  rmag_op_e         op,
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [SEG_W-1:0] ss_o,
  output logic [OFF_W-1:0] stk_off_o
);
  localparam logic [OFF_W-1:0] STEP = OFF_W'(WORD_BYTES);

  logic [SEG_W-1:0] ss_q, ss_d;
  logic [OFF_W-1:0] sp_q, sp_d;
  logic             ss_en, sp_en;
  logic [OFF_W-1:0] sp_dec, sp_inc;

  assign sp_dec = sp_q - STEP;
  assign sp_inc = sp_q + STEP;

  always_comb begin
    ss_en = 1'b0;
    sp_en = 1'b0;
    ss_d  = ss_q;
    sp_d  = sp_q;
    if (req_valid) begin
      unique case (op)
        OP_PUSH: begin sp_en = 1'b1; sp_d = sp_dec; end
        OP_POP:  begin sp_en = 1'b1; sp_d = sp_inc; end
        OP_LOAD: begin
          ss_en = 1'b1; ss_d = seg_i;
          sp_en = 1'b1; sp_d = off_i;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_q <= '0;
      sp_q <= '0;
    end else begin
      if (ss_en) ss_q <= ss_d;
      if (sp_en) sp_q <= sp_d;
    end
  end

  assign ss_o      = ss_q;
  assign stk_off_o = (op == OP_PUSH) ? sp_dec : sp_q;

  assert_push_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == OP_PUSH) |=> (sp_q == $past(sp_q) - STEP));
  assert_pop_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == OP_POP) |=> (sp_q == $past(sp_q) + STEP));
  assert_access_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || op == OP_ACCESS) |=> ($stable(sp_q) && $stable(ss_q)));
endmodule

// File: rtl/rm_addr_gen.sv
module rm_addr_gen
  import rmag_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic [15:0] seg,
  input  logic [15:0] off,
  input  logic        wide_bus,
  input  logic        hi_bit_en,
  output logic [23:0] phys_addr,
  output logic        addr_valid
);
  rmag_op_e         op;
  logic [SEG_W-1:0] ss;
  logic [OFF_W-1:0] stk_off;
  logic [SEG_W-1:0] sel_seg;
  logic [OFF_W-1:0] sel_off;
  logic [PA_W-1:0]  pa_comb;
  logic [PA_W-1:0]  addr_q, addr_d;
  logic             vld_q, vld_d;
  logic             issue;

  assign op = rmag_op_e'(req_op);

  rmag_stack #(.SEG_W(SEG_W), .OFF_W(OFF_W), .WORD_BYTES(2)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .op        (op),
    .seg_i     (seg),
    .off_i     (off),
    .ss_o      (ss),
    .stk_off_o (stk_off)
  );

  always_comb begin
    if (op == OP_PUSH || op == OP_POP) begin
      sel_seg = ss;
      sel_off = stk_off;
    end else begin
      sel_seg = seg;
      sel_off = off;
    end
  end

  rmag_xlate #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT),
    .PA_W(PA_W), .LEGACY_W(LEGACY_W)
  ) u_xlate (
    .seg_i  (sel_seg),
    .off_i  (sel_off),
    .wide_i (wide_bus),
    .gate_i (hi_bit_en),
    .pa_o   (pa_comb)
  );

  assign issue = req_valid && (op != OP_LOAD);

  always_comb begin
    vld_d  = issue;
    addr_d = addr_q;
    if (issue) addr_d = pa_comb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (issue) addr_q <= addr_d;
    end
  end

  assign phys_addr  = addr_q;
  assign addr_valid = vld_q;

  assert_hi_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[23:21] == 3'b000);
  assert_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op != 2'd3) |=> addr_valid);
  assert_no_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || req_op == 2'd3) |=> !addr_valid);
  assert_narrow_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op != 2'd3 && !wide_bus) |=> !phys_addr[20]);
  assert_gate_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op != 2'd3 && !hi_bit_en) |=> !phys_addr[20]);
endmodule

// File: tb/rm_addr_gen_tb.sv
module rm_addr_gen_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [15:0] seg, off;
  logic        wide_bus, hi_bit_en;
  logic [23:0] phys_addr;
  logic        addr_valid;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rm_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .seg(seg), .off(off), .wide_bus(wide_bus), .hi_bit_en(hi_bit_en),
    .phys_addr(phys_addr), .addr_valid(addr_valid)
  );

  function automatic logic [23:0] model(input logic [15:0] s, input logic [15:0] o,
                                        input logic w, input logic g);
    logic [23:0] r;
    r = {4'h0, s, 4'h0} + {8'h00, o};
    if (!w) r[23:20] = 4'h0;
    if (!g) r[20] = 1'b0;
    return r;
  endfunction

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %06h expected %06h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [15:0] s, input logic [15:0] o);
    req_valid = 1'b1; req_op = op; seg = s; off = o;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; seg = '0; off = '0;
    wide_bus = 1'b1; hi_bit_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 valid in reset", {23'd0, addr_valid}, 24'd0);
    chk("R10 addr in reset", phys_addr, 24'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 idle no strobe", {23'd0, addr_valid}, 24'd0);
  endtask

  task automatic t_corner();
    for (int m = 0; m < 4; m++) begin
      wide_bus = m[1]; hi_bit_en = m[0];
      issue(2'd0, 16'hFFFF, 16'hFFFF);
      chk("R1/R2/R3 FFFF:FFFF", phys_addr, model(16'hFFFF, 16'hFFFF, m[1], m[0]));
      chk("R4 high bits", {21'd0, phys_addr[23:21]}, 24'd0);
      issue(2'd0, 16'hFFFF, 16'h0010);
      chk("R1/R2/R3 FFFF:0010", phys_addr, model(16'hFFFF, 16'h0010, m[1], m[0]));
      issue(2'd0, 16'hFFFF, 16'h000F);
      chk("R1 FFFF:000F", phys_addr, 24'h0FFFFF);
    end
    wide_bus = 1'b1; hi_bit_en = 1'b1;
    issue(2'd0, 16'hFFFF, 16'hFFFF);
    chk("R1 max 10FFEF", phys_addr, 24'h10FFEF);
    wide_bus = 1'b0;
    issue(2'd0, 16'hFFFF, 16'h0010);
    chk("R2 wrap to zero", phys_addr, 24'h000000);
    wide_bus = 1'b1; hi_bit_en = 1'b0;
    issue(2'd0, 16'hFFFF, 16'hFFFF);
    chk("R3 gate clears bit20", phys_addr, 24'h00FFEF);
  endtask

  task automatic t_random();
    for (int m = 0; m < 4; m++) begin
      wide_bus = m[1]; hi_bit_en = m[0];
      for (int i = 0; i < 60; i++) begin
        logic [15:0] s, o;
        s = 16'($urandom); o = 16'($urandom);
        if (i < 10) s = 16'hF000 | s;
        issue(2'd0, s, o);
        chk("R1/R2/R3 random", phys_addr, model(s, o, m[1], m[0]));
        chk("R5 strobe", {23'd0, addr_valid}, 24'd1);
      end
    end
  endtask

  task automatic t_latency();
    wide_bus = 1'b1; hi_bit_en = 1'b1;
    issue(2'd0, 16'h1000, 16'h0001);
    chk("R5 strobe one cycle later", {23'd0, addr_valid}, 24'd1);
    chk("R1 addr", phys_addr, 24'h010001);
    @(negedge clk);
    chk("R5 strobe drops", {23'd0, addr_valid}, 24'd0);
  endtask

  task automatic t_stack();
    wide_bus = 1'b1; hi_bit_en = 1'b1;
    issue(2'd1, 16'h0, 16'h0);
    chk("R8 push wraps SP to FFFE", phys_addr, 24'h00FFFE);
    issue(2'd2, 16'h0, 16'h0);
    chk("R7 pop uses current SP", phys_addr, 24'h00FFFE);
    issue(2'd2, 16'h0, 16'h0);
    chk("R8 pop wraps SP to 0000", phys_addr, 24'h000000);
    issue(2'd1, 16'h0, 16'h0);
    chk("R6 push returns to 0000", phys_addr, 24'h000000);
    issue(2'd3, 16'h1234, 16'h0010);
    chk("R9 load raises no strobe", {23'd0, addr_valid}, 24'd0);
    issue(2'd1, 16'h0, 16'h0);
    chk("R6 push pre-decrement", phys_addr, 24'h01234E);
    issue(2'd1, 16'h0, 16'h0);
    chk("R6 second push", phys_addr, 24'h01234C);
    issue(2'd0, 16'h0ABC, 16'h0003);
    chk("R9 access addr", phys_addr, 24'h00ABC3);
    issue(2'd2, 16'h0, 16'h0);
    chk("R9 access kept SP / R7 pop", phys_addr, 24'h01234C);
    issue(2'd2, 16'h0, 16'h0);
    chk("R7 second pop", phys_addr, 24'h01234E);
    issue(2'd3, 16'hFFFF, 16'h0020);
    issue(2'd1, 16'h0, 16'h0);
    chk("R11 push wide gate on", phys_addr, 24'h10000E);
    wide_bus = 1'b0;
    issue(2'd2, 16'h0, 16'h0);
    chk("R11 pop narrow wraps", phys_addr, 24'h00000E);
    wide_bus = 1'b1; hi_bit_en = 1'b0;
    issue(2'd1, 16'h0, 16'h0);
    chk("R11 push gate off", phys_addr, 24'h00000E);
    hi_bit_en = 1'b1;
    issue(2'd2, 16'h0, 16'h0);
    chk("R11 pop gate on", phys_addr, 24'h10000E);
    issue(2'd1, 16'h0, 16'h0);
    chk("R6 SP back at 0020 after pop", phys_addr, 24'h10000E);
  endtask

  initial begin
    t_reset();
    t_corner();
    t_random();
    t_latency();
    t_stack();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule